// File: doc/BRIEF.md
# Supply Undervoltage Monitor Controller

This block is the digital side of a supply-voltage watchdog. Two comparator outputs arrive from an analog front end. One reports that the supply has dropped below the lower trip level. The other reports that the supply has climbed above the upper trip level. Both inputs are asynchronous. The block synchronises them and keeps a single hysteresis status bit. That bit is set by the lower-trip input and cleared only by the upper-trip input, so a supply that sits near the lower threshold cannot make it chatter.

Each change of the status bit, in either direction, sets an event flag. The flag can raise an interrupt request. Software clears the flag through a write-one acknowledge bit. If resets are permitted, the block also drives a level reset request. That request holds for as long as the status bit stays set, and it takes priority over the interrupt: when it rises it clears the interrupt enable. Two static configuration inputs control the block. One powers the monitor down. The other forbids resets, so that only polling and interrupts remain. A small register port exposes the enable, the acknowledge, the flag, the status and a read-only view of the two configuration inputs. The port has a combinational read path and one write strobe. It carries no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `supmon_ctrl`

## Requirements
- R1: While `cfg_pwrdn_i` is 1, the status bit, the event flag, `irq_o` and `lvrst_o` are all 0 from the next clock edge on, whatever the comparator inputs do.
- R2: The status bit is set by the synchronised lower-trip input. Once set, it stays set after that input returns to 0, and it is cleared only when the synchronised upper-trip input is 1.
- R3: Each comparator input passes through a two-stage synchroniser. A change on an input reaches the status bit on the third rising clock edge after it is applied, and not on the second.
- R4: The event flag is set on every change of the status bit, both 0→1 and 1→0.
- R5: `irq_o` is 1 exactly when the event flag is 1, the interrupt enable is 1 and `lvrst_o` is 0.
- R6: Writing 1 to the acknowledge bit (register 0, bit 1) clears the event flag. Writing 0 to that bit leaves the flag alone. The acknowledge bit always reads as 0.
- R7: If a status change and an acknowledge write land on the same clock edge, the flag ends up set.
- R8: `lvrst_o` is 1 while the status bit is 1, `cfg_pwrdn_i` is 0 and `cfg_rstdis_i` is 0, and it stays 1 until the upper-trip input clears the status. With `cfg_rstdis_i` at 1, it never asserts.
- R9: On the edge where `lvrst_o` rises, the interrupt enable is cleared, and this clear overrides a write on that same edge.
- R10: Register 0 holds the enable in bit 0 (read/write), the acknowledge in bit 1, the flag in bit 6 and the status in bit 7. Writes to bits 6 and 7 are ignored. Register 1 reads `cfg_pwrdn_i` in bit 0 and `cfg_rstdis_i` in bit 1. Every other address reads 0.
- R11: Driving `rst_ni` low clears the status, the flag, the enable and `lvrst_o` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| below_fall_i | input | 1 | Asynchronous comparator: supply below the lower trip level |
| above_rise_i | input | 1 | Asynchronous comparator: supply above the upper trip level |
| cfg_pwrdn_i | input | 1 | Static configuration: 1 powers the monitor down |
| cfg_rstdis_i | input | 1 | Static configuration: 1 forbids the reset request |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wr_i | input | 1 | Register write strobe, taken at the clock edge |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Combinational register read data |
| irq_o | output | 1 | Interrupt request |
| lvrst_o | output | 1 | Registered reset request level |

## Verification
The bench targets the corner cases most likely to be got wrong, and names the failure each one would show. The hysteresis hold tests that dropping the lower-trip input alone does not clear the status; a design that simply follows that input would lose the condition early. The falling edge of the status must set the flag too; a design that detects only the rising edge would miss that recovery event. An acknowledge write on the same edge as a status change must leave the flag set; if the acknowledge won, that event would be lost. The reset-path test checks that the enable is cleared when the reset rises, that the interrupt stays quiet while the reset is held, and that the reset does not end until the upper-trip input is seen. A latency probe one edge early catches a synchroniser that is missing a stage.

// File: rtl/supmon_pkg.sv
package supmon_pkg;
  localparam int unsigned REG_DW = 8;

  // register 0 field positions
  localparam int unsigned IEN_BIT  = 0;
  localparam int unsigned ACK_BIT  = 1;
  localparam int unsigned FLAG_BIT = 6;
  localparam int unsigned STAT_BIT = 7;

  // register 1 field positions
  localparam int unsigned PWRDN_BIT  = 0;
  localparam int unsigned RSTDIS_BIT = 1;

  localparam int unsigned CSR_INDEX = 0;
  localparam int unsigned CFG_INDEX = 1;

  typedef enum logic {
    LV_OK  = 1'b0,
    LV_LOW = 1'b1
  } lv_state_t;

  typedef struct packed {
    logic rstdis;
    logic pwrdn;
  } cfg_t;
endpackage

// File: rtl/supmon_sync.sv
module supmon_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= '0;
        else         chain_q[g] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= '0;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/supmon_hyst.sv
module supmon_hyst
  import supmon_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pwrdn_i,
  input  logic      below_i,
  input  logic      above_i,
  output lv_state_t state_q,
  output lv_state_t state_nx,
  output logic      toggle_o
);
  always_comb begin
    state_nx = state_q;
    if (pwrdn_i) begin
      state_nx = LV_OK;
    end else begin
      unique case (state_q)
        LV_OK:   if (below_i) state_nx = LV_LOW;
        LV_LOW:  if (above_i) state_nx = LV_OK;
        default: state_nx = LV_OK;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LV_OK;
    else         state_q <= state_nx;
  end

  // a power-down forced clear is not a monitored event
  assign toggle_o = (state_nx != state_q) && !pwrdn_i;
endmodule

// File: rtl/supmon_rstgen.sv
module supmon_rstgen
  import supmon_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  cfg_t      cfg_i,
  input  lv_state_t state_nx,
  output logic      lvrst_q,
  output logic      rise_o
);
  logic req_nx;

  assign req_nx = !cfg_i.pwrdn && !cfg_i.rstdis && (state_nx == LV_LOW);
  assign rise_o = req_nx && !lvrst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvrst_q <= 1'b0;
    else         lvrst_q <= req_nx;
  end
endmodule

// File: rtl/supmon_irq.sv
module supmon_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwrdn_i,
  input  logic toggle_i,
  input  logic ack_wr_i,
  input  logic en_wr_i,
  input  logic en_wdata_i,
  input  logic rst_rise_i,
  input  logic lvrst_i,
  output logic flag_q,
  output logic ien_q,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (pwrdn_i)  flag_q <= 1'b0;
    else if (toggle_i) flag_q <= 1'b1;
    else if (ack_wr_i) flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ien_q <= 1'b0;
    else if (rst_rise_i) ien_q <= 1'b0;
    else if (en_wr_i)    ien_q <= en_wdata_i;
  end

  assign irq_o = flag_q && ien_q && !lvrst_i;
endmodule

// File: rtl/supmon_regs.sv
module supmon_regs
  import supmon_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic              ien_i,
  input  logic              flag_i,
  input  logic              status_i,
  input  cfg_t              cfg_i,
  output logic              en_wr_o,
  output logic              en_wdata_o,
  output logic              ack_wr_o,
  output logic [REG_DW-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] CSR_A = ADDR_W'(CSR_INDEX);
  localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_INDEX);

  logic csr_sel;
  logic cfg_sel;
  logic wdata_unused;

  assign csr_sel      = (addr_i == CSR_A);
  assign cfg_sel      = (addr_i == CFG_A);
  assign en_wr_o      = wr_i && csr_sel;
  assign en_wdata_o   = wdata_i[IEN_BIT];
  assign ack_wr_o     = wr_i && csr_sel && wdata_i[ACK_BIT];
  assign wdata_unused = ^wdata_i;

  always_comb begin
    rdata_o = '0;
    if (csr_sel) begin
      rdata_o[IEN_BIT]  = ien_i;
      rdata_o[FLAG_BIT] = flag_i;
      rdata_o[STAT_BIT] = status_i;
    end else if (cfg_sel) begin
      rdata_o[PWRDN_BIT]  = cfg_i.pwrdn;
      rdata_o[RSTDIS_BIT] = cfg_i.rstdis;
    end
  end
endmodule

// File: rtl/supmon_ctrl.sv
module supmon_ctrl
  import supmon_pkg::*;
#(
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              below_fall_i,
  input  logic              above_rise_i,
  input  logic              cfg_pwrdn_i,
  input  logic              cfg_rstdis_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              irq_o,
  output logic              lvrst_o
);
  cfg_t      cfg;
  logic      below_s, above_s;
  lv_state_t mon_state, mon_state_nx;
  logic      toggle, rst_rise, status_bit;
  logic      flag_q, ien_q;
  logic      en_wr, en_wdata, ack_wr;

  assign cfg.pwrdn  = cfg_pwrdn_i;
  assign cfg.rstdis = cfg_rstdis_i;

  supmon_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({above_rise_i, below_fall_i}),
    .sync_o ({above_s, below_s})
  );

  supmon_hyst u_hyst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pwrdn_i (cfg.pwrdn),
    .below_i (below_s),
    .above_i (above_s),
    .state_q (mon_state),
    .state_nx(mon_state_nx),
    .toggle_o(toggle)
  );

  supmon_rstgen u_rstgen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cfg_i   (cfg),
    .state_nx(mon_state_nx),
    .lvrst_q (lvrst_o),
    .rise_o  (rst_rise)
  );

  supmon_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwrdn_i   (cfg.pwrdn),
    .toggle_i  (toggle),
    .ack_wr_i  (ack_wr),
    .en_wr_i   (en_wr),
    .en_wdata_i(en_wdata),
    .rst_rise_i(rst_rise),
    .lvrst_i   (lvrst_o),
    .flag_q    (flag_q),
    .ien_q     (ien_q),
    .irq_o     (irq_o)
  );

  assign status_bit = (mon_state == LV_LOW);

  supmon_regs #(.ADDR_W(ADDR_W)) u_regs (
    .addr_i    (reg_addr_i),
    .wr_i      (reg_wr_i),
    .wdata_i   (reg_wdata_i),
    .ien_i     (ien_q),
    .flag_i    (flag_q),
    .status_i  (status_bit),
    .cfg_i     (cfg),
    .en_wr_o   (en_wr),
    .en_wdata_o(en_wdata),
    .ack_wr_o  (ack_wr),
    .rdata_o   (reg_rdata_o)
  );
endmodule

// File: rtl/supmon_chk.sv
module supmon_chk #(
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pwrdn,
  input logic              rstdis,
  input logic              above_s,
  input logic              status,
  input logic              flag,
  input logic              ien,
  input logic              irq,
  input logic              lvrst,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        rdata
);
  assert_pwrdn_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrdn |=> (!status && !flag && !irq && !lvrst));

  assert_hyst_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status && !above_s && !pwrdn) |=> status);

  assert_flag_on_change_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status != $past(status)) && !$past(pwrdn)) |-> flag);

  assert_irq_needs_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq |-> (flag && ien && !lvrst));

  assert_ack_reads_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr == '0) |-> !rdata[1]);

  assert_rst_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvrst |-> (status && !$past(rstdis) && !$past(pwrdn)));

  assert_trip_clears_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lvrst) |-> !ien);
endmodule

bind supmon_ctrl supmon_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .pwrdn  (cfg_pwrdn_i),
  .rstdis (cfg_rstdis_i),
  .above_s(above_s),
  .status (status_bit),
  .flag   (flag_q),
  .ien    (ien_q),
  .irq    (irq_o),
  .lvrst  (lvrst_o),
  .addr   (reg_addr_i),
  .rdata  (reg_rdata_o)
);

// File: tb/supmon_ctrl_tb.sv
`timescale 1ns/1ps
module supmon_ctrl_tb;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          below = 1'b0, above = 1'b0;
  logic          pwrdn = 1'b0, rstdis = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          irq, lvrst;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  supmon_ctrl #(.ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .below_fall_i(below), .above_rise_i(above),
    .cfg_pwrdn_i(pwrdn), .cfg_rstdis_i(rstdis), .reg_addr_i(addr),
    .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .lvrst_o(lvrst)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wr_reg(input logic [AW-1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
  endtask

  // returns register 0: bit0 enable, bit6 flag, bit7 status
  task automatic csr(output logic [7:0] d);
    rd('0, d);
  endtask

  task automatic clear_low();
    above = 1'b1; step(3); above = 1'b0; step(1);
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    csr(d);
    check("R11 csr after reset", d, 8'h00);
    check("R11 outputs after reset", {6'b0, irq, lvrst}, 8'h00);
  endtask

  task automatic t_sync_hyst();
    logic [7:0] d;
    below = 1'b1;
    step(2); csr(d);
    check("R3 status not yet at edge 2", d & 8'h80, 8'h00);
    step(1); csr(d);
    check("R3 status set at edge 3", d & 8'hC0, 8'hC0);
    below = 1'b0;
    step(5); csr(d);
    check("R2 status held after lower input drops", d & 8'h80, 8'h80);
    wr_reg('0, 8'h02);
    above = 1'b1;
    step(3); csr(d);
    check("R2 status cleared by upper input", d & 8'h80, 8'h00);
    check("R4 flag set on falling status", d & 8'h40, 8'h40);
    above = 1'b0; step(1);
  endtask

  task automatic t_ack();
    logic [7:0] d;
    wr_reg('0, 8'h00);
    csr(d);
    check("R6 ack written 0 keeps flag", d & 8'h40, 8'h40);
    wr_reg('0, 8'h02);
    csr(d);
    check("R6 ack written 1 clears flag", d & 8'h40, 8'h00);
    check("R6 ack bit reads 0", d & 8'h02, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    wr_reg('0, 8'h01);
    check("R5 no irq without flag", {7'b0, irq}, 8'h00);
    below = 1'b1; step(3); below = 1'b0;
    check("R5 irq with flag and enable", {7'b0, irq}, 8'h01);
    wr_reg('0, 8'h00);
    check("R5 irq off when enable cleared", {7'b0, irq}, 8'h00);
    wr_reg('0, 8'h03);
    check("R5 irq off after ack", {7'b0, irq}, 8'h00);
    csr(d);
    check("R10 enable kept by ack write", d & 8'h01, 8'h01);
    clear_low();
    wr_reg('0, 8'h02);
  endtask

  task automatic t_same_edge();
    logic [7:0] d;
    below = 1'b1; step(3); below = 1'b0;
    above = 1'b1; step(2);
    wr_reg('0, 8'h02);
    csr(d);
    check("R7 toggle beats ack on same edge", d & 8'hC0, 8'h40);
    above = 1'b0;
    wr_reg('0, 8'h02);
  endtask

  task automatic t_reset_path();
    logic [7:0] d;
    rstdis = 1'b0;
    wr_reg('0, 8'h01);
    below = 1'b1; step(2);
    check("R8 reset not before status", {7'b0, lvrst}, 8'h00);
    step(1);
    check("R8 reset asserted on trip", {7'b0, lvrst}, 8'h01);
    csr(d);
    check("R9 enable cleared by trip", d & 8'h01, 8'h00);
    check("R5 no irq during reset", {7'b0, irq}, 8'h00);
    below = 1'b0; step(6);
    check("R8 reset held without upper input", {7'b0, lvrst}, 8'h01);
    above = 1'b1; step(2);
    check("R8 reset still held at edge 2", {7'b0, lvrst}, 8'h01);
    step(1);
    check("R8 reset released by upper input", {7'b0, lvrst}, 8'h00);
    above = 1'b0;
    wr_reg('0, 8'h02);
    rstdis = 1'b1;
    below = 1'b1; step(4); below = 1'b0;
    check("R8 no reset when disabled", {7'b0, lvrst}, 8'h00);
    clear_low();
    wr_reg('0, 8'h02);
  endtask

  task automatic t_pwrdn();
    logic [7:0] d;
    pwrdn = 1'b1; rstdis = 1'b0;
    wr_reg('0, 8'h01);
    below = 1'b1; step(5);
    csr(d);
    check("R1 status and flag held 0", d & 8'hC0, 8'h00);
    check("R1 irq and reset held 0", {6'b0, irq, lvrst}, 8'h00);
    rd(AW'(1), d);
    check("R10 config register", d, 8'h01);
    below = 1'b0; step(3);
    pwrdn = 1'b0; rstdis = 1'b1; step(3);
    rd(AW'(1), d);
    check("R10 config register rstdis", d, 8'h02);
    wr_reg('0, 8'h00);
  endtask

  task automatic t_regmap();
    logic [7:0] d;
    wr_reg('0, 8'hFD);
    csr(d);
    check("R10 only enable is writable", d, 8'h01);
    rd(AW'(2), d);
    check("R10 unmapped address reads 0", d, 8'h00);
    wr_reg('0, 8'h00);
  endtask

  task automatic t_async_reset();
    logic [7:0] d;
    wr_reg('0, 8'h01);
    below = 1'b1; step(3); below = 1'b0; step(1);
    #1 rst_n = 1'b0;
    #1 csr(d);
    check("R11 async clear of csr", d, 8'h00);
    check("R11 async clear of irq", {7'b0, irq}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1);
    t_reset_state();
    t_sync_hyst();
    t_ack();
    t_irq();
    t_same_edge();
    t_reset_path();
    t_pwrdn();
    t_regmap();
    t_async_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1600000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule